// File: doc/BRIEF.md
# Single-Channel Peripheral DMA Engine

This block is one DMA channel. It copies elements between one memory-mapped peripheral data register and a RAM buffer reserved for the channel, and the processor is not involved once the channel is set up. Software uses a small register port to set the direction, the element width, the addressing mode, the run mode, the buffer start offset, the peripheral address, the element count and the code of the request source. It then sets the enable bit. Each request from the matching peripheral moves exactly one element. Each element has a read phase on the source side, followed by a write phase on the destination side.

A block ends after the programmed count plus one elements. At that point the channel pulses an interrupt and sets a sticky done flag. In continuous mode the channel then reloads the start offset and the count and waits for more requests. In one-shot mode it switches itself off. A force bit lets software start one transfer without a peripheral request. A request that arrives while an element is in flight is held as a single pending request. A second overlapping request is recorded in a sticky collision flag.

Top module: `pdma_channel`

## Requirements
- R1: With the enable bit (CTRL bit 0, register offset 0) at 0, the channel issues no peripheral or RAM strobe and ignores requests. After reset every register and flag reads 0.
- R2: Only a request whose 7-bit code equals the select field (REQSEL bits 6:0, offset 4) starts an element. A request with any other code is ignored.
- R3: With the direction bit (CTRL bit 1) at 0, an element reads the peripheral (per_re) in one cycle and writes the RAM (ram_we) in the next cycle. With the direction bit at 1, it reads the RAM and then writes the peripheral. Per_addr carries the peripheral address register (offset 2). At most one strobe is active in any cycle.
- R4: The RAM address starts at the start offset (offset 1). After each element it advances by 1 in byte mode or by 2 in word mode, and it wraps at the top of the buffer space. With the hold bit (CTRL bit 3) at 1, the address stays at the start offset.
- R5: The size bit (CTRL bit 2) selects 8-bit elements when it is 1 and 16-bit elements when it is 0. A byte uses RAM lane addr[0] (ram_be 01 for even, 10 for odd) and travels zero-extended in bits 7:0 on the peripheral side. A word uses ram_be 11.
- R6: A block ends after COUNT+1 elements (COUNT at offset 3). blk_irq is high for exactly the one cycle after the write cycle of the last element, and the done flag (STATUS bit 0, offset 5) is set.
- R7: In continuous mode (CTRL bit 4 at 0), the next block starts at the start offset with no software action. In one-shot mode (CTRL bit 4 at 1), the enable bit clears when the block ends.
- R8: Writing REQSEL bit 15 as 1 starts one element exactly as a request would. The bit reads back 0 once the request has been accepted.
- R9: A matching request that arrives during an element is queued as one pending request and runs after that element. A further matching request while one is already pending sets the collision flag (STATUS bit 1).
- R10: Writing 0 to a STATUS bit clears that flag. Writing 1 leaves it unchanged.
- R11: Clearing the enable bit in the middle of a block abandons the block. After the channel is enabled again, it restarts at the start offset with the full count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| dreq_valid | input | 1 | Peripheral request pulse |
| dreq_code | input | 7 | Code of the requesting peripheral |
| per_addr | output | PADDR_W | Peripheral data register address |
| per_re | output | 1 | Peripheral read strobe (data returns next cycle) |
| per_we | output | 1 | Peripheral write strobe |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data |
| ram_addr | output | ADDR_W | RAM byte address |
| ram_re | output | 1 | RAM read strobe (data returns next cycle) |
| ram_we | output | 1 | RAM write strobe |
| ram_be | output | 2 | RAM byte lane enables |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data (aligned 16-bit word) |
| blk_irq | output | 1 | One-cycle block-complete pulse |

## Verification
The bench builds the channel with ADDR_W=6, PADDR_W=8 and CNT_W=8. A 64-byte buffer lets a word block that starts at offset 62 run over the top and wrap to offset 0, and lets the bench hold a full byte image of the buffer so it can compare every lane. An 8-bit count keeps blocks short, so a continuous re-arm, a one-shot stop and a restart after an abort each take only a few dozen cycles.

// File: rtl/pdma_pkg.sv
package pdma_pkg;
  localparam int DW = 16;
  localparam int SEL_W = 7;

  localparam logic [2:0] RA_CTRL   = 3'd0;
  localparam logic [2:0] RA_START  = 3'd1;
  localparam logic [2:0] RA_PADDR  = 3'd2;
  localparam logic [2:0] RA_COUNT  = 3'd3;
  localparam logic [2:0] RA_REQSEL = 3'd4;
  localparam logic [2:0] RA_STATUS = 3'd5;

  localparam int FORCE_BIT = 15;

  typedef enum logic [1:0] {XS_IDLE, XS_RD, XS_WR} xstate_t;

  typedef struct packed {
    logic oneshot;
    logic hold;
    logic bytesz;
    logic dir;
    logic en;
  } ctrl_t;
endpackage

// File: rtl/pdma_regs.sv
module pdma_regs
  import pdma_pkg::*;
#(
  parameter int AW = 12,
  parameter int PW = 12,
  parameter int CW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic [DW-1:0]    reg_wdata,
  input  logic             force_take,
  input  logic             blk_end,
  input  logic             coll_set,
  output ctrl_t            ctrl,
  output logic [AW-1:0]    start,
  output logic [PW-1:0]    paddr,
  output logic [CW-1:0]    count,
  output logic [SEL_W-1:0] sel,
  output logic             force_q,
  output logic             done_q,
  output logic             coll_q,
  output logic [DW-1:0]    reg_rdata
);
  logic wr_ctrl, wr_start, wr_paddr, wr_count, wr_sel, wr_stat;
  ctrl_t            ctrl_n;
  logic [AW-1:0]    start_n;
  logic [PW-1:0]    paddr_n;
  logic [CW-1:0]    count_n;
  logic [SEL_W-1:0] sel_n;
  logic             force_n, done_n, coll_n;

  assign wr_ctrl  = reg_we && (reg_addr == RA_CTRL);
  assign wr_start = reg_we && (reg_addr == RA_START);
  assign wr_paddr = reg_we && (reg_addr == RA_PADDR);
  assign wr_count = reg_we && (reg_addr == RA_COUNT);
  assign wr_sel   = reg_we && (reg_addr == RA_REQSEL);
  assign wr_stat  = reg_we && (reg_addr == RA_STATUS);

  always_comb begin
    ctrl_n = ctrl;
    if (wr_ctrl) begin
      ctrl_n = ctrl_t'(reg_wdata[4:0]);
    end else if (blk_end && ctrl.oneshot) begin
      ctrl_n.en = 1'b0;
    end
    start_n = wr_start ? reg_wdata[AW-1:0] : start;
    paddr_n = wr_paddr ? reg_wdata[PW-1:0] : paddr;
    count_n = wr_count ? reg_wdata[CW-1:0] : count;
    sel_n   = wr_sel   ? reg_wdata[SEL_W-1:0] : sel;
    force_n = wr_sel   ? reg_wdata[FORCE_BIT] : (force_q && !force_take);
    done_n  = blk_end  || (done_q && !(wr_stat && !reg_wdata[0]));
    coll_n  = coll_set || (coll_q && !(wr_stat && !reg_wdata[1]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      start   <= '0;
      paddr   <= '0;
      count   <= '0;
      sel     <= '0;
      force_q <= 1'b0;
      done_q  <= 1'b0;
      coll_q  <= 1'b0;
    end else begin
      ctrl    <= ctrl_n;
      start   <= start_n;
      paddr   <= paddr_n;
      count   <= count_n;
      sel     <= sel_n;
      force_q <= force_n;
      done_q  <= done_n;
      coll_q  <= coll_n;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      RA_CTRL:   reg_rdata[4:0] = ctrl;
      RA_START:  reg_rdata[AW-1:0] = start;
      RA_PADDR:  reg_rdata[PW-1:0] = paddr;
      RA_COUNT:  reg_rdata[CW-1:0] = count;
      RA_REQSEL: begin
        reg_rdata[SEL_W-1:0] = sel;
        reg_rdata[FORCE_BIT] = force_q;
      end
      RA_STATUS: reg_rdata[1:0] = {coll_q, done_q};
      default:   reg_rdata = '0;
    endcase
  end

  // R8
  force_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_take && !wr_sel) |=> !force_q);

  // R6
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blk_end |=> done_q);
endmodule

// File: rtl/pdma_reqq.sv
module pdma_reqq
  import pdma_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             idle,
  input  logic             dreq_valid,
  input  logic [SEL_W-1:0] dreq_code,
  input  logic [SEL_W-1:0] sel,
  input  logic             force_q,
  output logic             go,
  output logic             force_take,
  output logic             coll_set
);
  logic hit, pend_q, pend_n;

  assign hit        = dreq_valid && (dreq_code == sel);
  assign go         = en && idle && (pend_q || hit || force_q);
  assign force_take = go && !pend_q && !hit;
  assign coll_set   = en && !go && hit && pend_q;

  always_comb begin
    if (!en) begin
      pend_n = 1'b0;
    end else if (go) begin
      pend_n = pend_q && hit;
    end else begin
      pend_n = pend_q || hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
    end
  end

  // R9
  pend_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && idle && en) |=> !idle);

  // R9
  coll_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    coll_set |-> (pend_q && !idle));
endmodule

// File: rtl/pdma_xfer.sv
module pdma_xfer
  import pdma_pkg::*;
#(
  parameter int AW = 12,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctrl_t         ctrl,
  input  logic [AW-1:0] start,
  input  logic [CW-1:0] count,
  input  logic          go,
  input  logic [DW-1:0] per_rdata,
  input  logic [DW-1:0] ram_rdata,
  output logic          idle,
  output logic          blk_end,
  output logic          irq,
  output logic          per_re,
  output logic          per_we,
  output logic [DW-1:0] per_wdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_re,
  output logic          ram_we,
  output logic [1:0]    ram_be,
  output logic [DW-1:0] ram_wdata
);
  localparam logic [AW-1:0] STEP_B = AW'(1);
  localparam logic [AW-1:0] STEP_W = AW'(2);

  xstate_t       st_q, st_n;
  logic [AW-1:0] addr_q, addr_n, step;
  logic [CW-1:0] ecnt_q, ecnt_n;
  logic          last;
  logic [7:0]    ram_lane;

  assign idle    = (st_q == XS_IDLE);
  assign last    = (ecnt_q == count);
  assign blk_end = ctrl.en && (st_q == XS_WR) && last;
  assign step    = ctrl.hold ? '0 : (ctrl.bytesz ? STEP_B : STEP_W);

  always_comb begin
    st_n   = st_q;
    addr_n = addr_q;
    ecnt_n = ecnt_q;
    if (!ctrl.en) begin
      st_n   = XS_IDLE;
      addr_n = start;
      ecnt_n = '0;
    end else begin
      case (st_q)
        XS_IDLE: if (go) st_n = XS_RD;
        XS_RD:   st_n = XS_WR;
        XS_WR: begin
          st_n = XS_IDLE;
          if (last) begin
            addr_n = start;
            ecnt_n = '0;
          end else begin
            addr_n = addr_q + step;
            ecnt_n = ecnt_q + CW'(1);
          end
        end
        default: st_n = XS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= XS_IDLE;
      addr_q <= '0;
      ecnt_q <= '0;
      irq    <= 1'b0;
    end else begin
      st_q   <= st_n;
      addr_q <= addr_n;
      ecnt_q <= ecnt_n;
      irq    <= blk_end;
    end
  end

  assign ram_addr = addr_q;
  assign per_re   = (st_q == XS_RD) && !ctrl.dir;
  assign ram_re   = (st_q == XS_RD) &&  ctrl.dir;
  assign ram_we   = (st_q == XS_WR) && !ctrl.dir;
  assign per_we   = (st_q == XS_WR) &&  ctrl.dir;
  assign ram_lane = addr_q[0] ? ram_rdata[15:8] : ram_rdata[7:0];

  always_comb begin
    if (ctrl.bytesz) begin
      ram_be    = addr_q[0] ? 2'b10 : 2'b01;
      ram_wdata = {per_rdata[7:0], per_rdata[7:0]};
      per_wdata = {8'h00, ram_lane};
    end else begin
      ram_be    = 2'b11;
      ram_wdata = per_rdata;
      per_wdata = ram_rdata;
    end
  end

  // R3
  one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({per_re, per_we, ram_re, ram_we}));

  // R3
  wr_after_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (per_re || ram_re) |=> (per_we || ram_we || !ctrl.en));

  // R6
  irq_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  // R1
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl.en |=> idle);
endmodule

// File: rtl/pdma_channel.sv
module pdma_channel
  import pdma_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int PADDR_W = 12,
  parameter int CNT_W   = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_we,
  input  logic [2:0]         reg_addr,
  input  logic [15:0]        reg_wdata,
  output logic [15:0]        reg_rdata,
  input  logic               dreq_valid,
  input  logic [6:0]         dreq_code,
  output logic [PADDR_W-1:0] per_addr,
  output logic               per_re,
  output logic               per_we,
  output logic [15:0]        per_wdata,
  input  logic [15:0]        per_rdata,
  output logic [ADDR_W-1:0]  ram_addr,
  output logic               ram_re,
  output logic               ram_we,
  output logic [1:0]         ram_be,
  output logic [15:0]        ram_wdata,
  input  logic [15:0]        ram_rdata,
  output logic               blk_irq
);
  logic             rst_meta, rst_sync;
  ctrl_t            ctrl;
  logic [ADDR_W-1:0] start;
  logic [CNT_W-1:0] count;
  logic [SEL_W-1:0] sel;
  logic             force_q, done_q, coll_q;
  logic             go, force_take, coll_set, idle, blk_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  pdma_regs #(.AW(ADDR_W), .PW(PADDR_W), .CW(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync),
    .reg_we     (reg_we),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .force_take (force_take),
    .blk_end    (blk_end),
    .coll_set   (coll_set),
    .ctrl       (ctrl),
    .start      (start),
    .paddr      (per_addr),
    .count      (count),
    .sel        (sel),
    .force_q    (force_q),
    .done_q     (done_q),
    .coll_q     (coll_q),
    .reg_rdata  (reg_rdata)
  );

  pdma_reqq u_reqq (
    .clk        (clk),
    .rst_n      (rst_sync),
    .en         (ctrl.en),
    .idle       (idle),
    .dreq_valid (dreq_valid),
    .dreq_code  (dreq_code),
    .sel        (sel),
    .force_q    (force_q),
    .go         (go),
    .force_take (force_take),
    .coll_set   (coll_set)
  );

  pdma_xfer #(.AW(ADDR_W), .CW(CNT_W)) u_xfer (
    .clk       (clk),
    .rst_n     (rst_sync),
    .ctrl      (ctrl),
    .start     (start),
    .count     (count),
    .go        (go),
    .per_rdata (per_rdata),
    .ram_rdata (ram_rdata),
    .idle      (idle),
    .blk_end   (blk_end),
    .irq       (blk_irq),
    .per_re    (per_re),
    .per_we    (per_we),
    .per_wdata (per_wdata),
    .ram_addr  (ram_addr),
    .ram_re    (ram_re),
    .ram_we    (ram_we),
    .ram_be    (ram_be),
    .ram_wdata (ram_wdata)
  );

  // R9
  coll_from_pend_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    $rose(coll_q) |-> $past(!idle));

  // R7
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (blk_end && ctrl.oneshot && !(reg_we && reg_addr == RA_CTRL)) |=> !ctrl.en);
endmodule

// File: tb/sim_pdma_channel.sv
module sim_pdma_channel;
  localparam int AW = 6;
  localparam int PW = 8;
  localparam int CW = 8;
  localparam int NB = 1 << AW;
  localparam logic [15:0] INC = 16'h0123;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic dreq_valid = 1'b0;
  logic [6:0] dreq_code = '0;
  logic [PW-1:0] per_addr;
  logic per_re, per_we;
  logic [15:0] per_wdata;
  logic [15:0] per_rdata = '0;
  logic [AW-1:0] ram_addr;
  logic ram_re, ram_we;
  logic [1:0] ram_be;
  logic [15:0] ram_wdata;
  logic [15:0] ram_rdata = '0;
  logic blk_irq;

  always #5 clk = ~clk;

  pdma_channel #(.ADDR_W(AW), .PADDR_W(PW), .CNT_W(CW)) u0 (.*);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  bit live = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // bench peripheral and RAM
  logic [7:0]  mem [NB];
  logic [15:0] pseq = 16'h1000;
  logic [15:0] pout [$];
  int irq_cnt = 0;

  always @(posedge clk) begin
    if (per_re) begin
      per_rdata <= pseq;
      pseq <= pseq + INC;
    end
    if (per_we) pout.push_back(per_wdata);
    if (ram_re) ram_rdata <= {mem[{ram_addr[AW-1:1], 1'b1}], mem[{ram_addr[AW-1:1], 1'b0}]};
    if (ram_we) begin
      if (ram_be[0]) mem[{ram_addr[AW-1:1], 1'b0}] <= ram_wdata[7:0];
      if (ram_be[1]) mem[{ram_addr[AW-1:1], 1'b1}] <= ram_wdata[15:8];
    end
    if (blk_irq) irq_cnt <= irq_cnt + 1;
  end

  function automatic logic [15:0] memw(input int a);
    return {mem[(a + 1) % NB], mem[a % NB]};
  endfunction

  // behavioural reference model, advanced on every rising edge
  int m_st = 0, m_addr = 0, m_ecnt = 0, m_start = 0, m_padr = 0, m_cnt = 0, m_sel = 0;
  bit m_en, m_dir, m_byte, m_hold, m_one, m_pend, m_force, m_done, m_coll, m_irq;

  always @(posedge clk) begin
    bit hit, go, ftake, bend, coll;
    if (!rst_n) begin
      m_st = 0; m_addr = 0; m_ecnt = 0; m_start = 0; m_padr = 0; m_cnt = 0; m_sel = 0;
      {m_en, m_dir, m_byte, m_hold, m_one} = '0;
      {m_pend, m_force, m_done, m_coll, m_irq} = '0;
    end else begin
      hit   = dreq_valid && (int'(dreq_code) == m_sel);
      go    = m_en && (m_st == 0) && (m_pend || hit || m_force);
      ftake = go && !m_pend && !hit;
      bend  = m_en && (m_st == 2) && (m_ecnt == m_cnt);
      coll  = m_en && !go && hit && m_pend;
      m_irq = bend;
      if (!m_en) begin
        m_pend = 0; m_st = 0; m_addr = m_start; m_ecnt = 0;
      end else begin
        m_pend = go ? (m_pend && hit) : (m_pend || hit);
        if (m_st == 0) m_st = go ? 1 : 0;
        else if (m_st == 1) m_st = 2;
        else begin
          m_st = 0;
          if (bend) begin m_addr = m_start; m_ecnt = 0; end
          else begin
            m_addr = (m_addr + (m_hold ? 0 : (m_byte ? 1 : 2))) % NB;
            m_ecnt = m_ecnt + 1;
          end
        end
      end
      if (ftake) m_force = 0;
      if (bend) m_done = 1;
      if (coll) m_coll = 1;
      if (bend && m_one) m_en = 0;
      if (reg_we) begin
        case (reg_addr)
          3'd0: {m_one, m_hold, m_byte, m_dir, m_en} = reg_wdata[4:0];
          3'd1: m_start = int'(reg_wdata[AW-1:0]);
          3'd2: m_padr = int'(reg_wdata[PW-1:0]);
          3'd3: m_cnt = int'(reg_wdata[CW-1:0]);
          3'd4: begin m_sel = int'(reg_wdata[6:0]); m_force = reg_wdata[15]; end
          3'd5: begin
            if (!reg_wdata[0] && !bend) m_done = 0;
            if (!reg_wdata[1] && !coll) m_coll = 0;
          end
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (live) begin
      bit e_pre, e_rre, e_pwe, e_rwe;
      logic [15:0] e_rw, e_pw;
      logic [7:0] lane;
      e_pre = (m_st == 1) && !m_dir;
      e_rre = (m_st == 1) &&  m_dir;
      e_rwe = (m_st == 2) && !m_dir;
      e_pwe = (m_st == 2) &&  m_dir;
      chk({per_re, per_we, ram_re, ram_we} == {e_pre, e_pwe, e_rre, e_rwe}, "R3 strobes",
          {per_re, per_we, ram_re, ram_we}, {e_pre, e_pwe, e_rre, e_rwe});
      chk(blk_irq == m_irq, "R6 blk_irq", blk_irq, m_irq);
      if (per_re || per_we)
        chk(int'(per_addr) == m_padr, "R3 per_addr", per_addr, m_padr);
      if (ram_re || ram_we)
        chk(int'(ram_addr) == m_addr, "R4 ram_addr", ram_addr, m_addr);
      if (ram_we) begin
        chk(ram_be == (m_byte ? (m_addr[0] ? 2'b10 : 2'b01) : 2'b11), "R5 ram_be",
            ram_be, m_byte ? (m_addr[0] ? 2 : 1) : 3);
        e_rw = m_byte ? {per_rdata[7:0], per_rdata[7:0]} : per_rdata;
        chk(ram_wdata == e_rw, "R5 ram_wdata", ram_wdata, e_rw);
      end
      if (per_we) begin
        lane = m_addr[0] ? ram_rdata[15:8] : ram_rdata[7:0];
        e_pw = m_byte ? {8'h00, lane} : ram_rdata;
        chk(per_wdata == e_pw, "R5 per_wdata", per_wdata, e_pw);
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic req(input logic [6:0] c);
    @(negedge clk);
    dreq_valid = 1'b1; dreq_code = c;
    @(negedge clk);
    dreq_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [15:0] v, p0;
    int irq0;
    for (int i = 0; i < NB; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;

    // reset state
    rd(3'd0, v); chk(v == 16'h0, "R1 ctrl after reset", v, 0);
    rd(3'd5, v); chk(v == 16'h0, "R1 status after reset", v, 0);

    // disabled channel ignores requests
    wr(3'd4, 16'h000A);
    wr(3'd2, 16'h0033);
    p0 = pseq;
    req(7'h0A);
    chk(pseq == p0, "R1 no read while disabled", pseq, p0);
    rd(3'd5, v); chk(v == 16'h0, "R1 no flag while disabled", v, 0);

    // word, peripheral to RAM, continuous; mismatched code ignored
    wr(3'd1, 16'd4);
    wr(3'd3, 16'd2);
    wr(3'd0, 16'h0001);
    p0 = pseq; irq0 = irq_cnt;
    req(7'h21);
    chk(pseq == p0, "R2 foreign code ignored", pseq, p0);
    req(7'h0A); req(7'h0A);
    chk(irq_cnt == irq0, "R6 no irq before last", irq_cnt, irq0);
    req(7'h0A);
    chk(irq_cnt == irq0 + 1, "R6 one irq per block", irq_cnt, irq0 + 1);
    req(7'h0A);
    chk(memw(6) == p0 + INC, "R3 R4 word at start+2", memw(6), p0 + INC);
    chk(memw(8) == p0 + 2 * INC, "R4 word at start+4", memw(8), p0 + 2 * INC);
    chk(memw(4) == p0 + 3 * INC, "R7 continuous restart at start", memw(4), p0 + 3 * INC);
    rd(3'd5, v); chk(v[0] == 1'b1, "R6 done flag", v, 1);

    // status clear semantics
    wr(3'd5, 16'h0003);
    rd(3'd5, v); chk(v[0] == 1'b1, "R10 write 1 keeps", v, 1);
    wr(3'd5, 16'h0000);
    rd(3'd5, v); chk(v == 16'h0, "R10 write 0 clears", v, 0);

    // byte, RAM to peripheral
    wr(3'd0, 16'h0000);
    mem[20] = 8'h11; mem[21] = 8'h22; mem[22] = 8'h33; mem[23] = 8'h44;
    wr(3'd1, 16'd20);
    wr(3'd3, 16'd3);
    wr(3'd0, 16'h0007);
    pout.delete(); irq0 = irq_cnt;
    for (int k = 0; k < 4; k++) req(7'h0A);
    chk(pout.size() == 4, "R3 four peripheral writes", pout.size(), 4);
    if (pout.size() == 4) begin
      chk(pout[0] == 16'h0011, "R5 byte lane 0", pout[0], 16'h0011);
      chk(pout[1] == 16'h0022, "R5 byte lane 1", pout[1], 16'h0022);
      chk(pout[3] == 16'h0044, "R4 byte step", pout[3], 16'h0044);
    end
    chk(irq_cnt == irq0 + 1, "R6 byte block irq", irq_cnt, irq0 + 1);

    // force request
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd56);
    wr(3'd3, 16'd7);
    wr(3'd0, 16'h0001);
    p0 = pseq;
    wr(3'd4, 16'h800A);
    repeat (6) @(negedge clk);
    rd(3'd4, v); chk(v == 16'h000A, "R8 force self-clears", v, 16'h000A);
    chk(pseq == p0 + INC, "R8 one forced element", pseq, p0 + INC);
    chk(memw(56) == p0, "R8 forced data stored", memw(56), p0);

    // pending and collision
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd32);
    wr(3'd0, 16'h0001);
    p0 = pseq;
    @(negedge clk); dreq_valid = 1'b1; dreq_code = 7'h0A;
    repeat (3) @(negedge clk);
    dreq_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(pseq == p0 + 2 * INC, "R9 pending runs, third lost", pseq, p0 + 2 * INC);
    chk(memw(34) == p0 + INC, "R9 queued element stored", memw(34), p0 + INC);
    rd(3'd5, v); chk(v[1] == 1'b1, "R9 collision flag", v, 2);
    wr(3'd5, 16'h0001);
    rd(3'd5, v); chk(v[1] == 1'b0, "R10 collision cleared", v, 0);

    // abort and restart
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd40);
    wr(3'd3, 16'd5);
    wr(3'd0, 16'h0001);
    req(7'h0A); req(7'h0A);
    wr(3'd0, 16'h0000);
    wr(3'd0, 16'h0001);
    p0 = pseq; irq0 = irq_cnt;
    for (int k = 0; k < 5; k++) req(7'h0A);
    chk(irq_cnt == irq0, "R11 full count after restart", irq_cnt, irq0);
    req(7'h0A);
    chk(irq_cnt == irq0 + 1, "R11 block ends after six", irq_cnt, irq0 + 1);
    chk(memw(40) == p0, "R11 restart at start", memw(40), p0);
    chk(memw(50) == p0 + 5 * INC, "R11 last of restarted block", memw(50), p0 + 5 * INC);

    // one-shot
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd10);
    wr(3'd3, 16'd0);
    wr(3'd0, 16'h0011);
    req(7'h0A);
    rd(3'd0, v); chk(v == 16'h0010, "R7 one-shot clears enable", v, 16'h0010);
    p0 = pseq;
    req(7'h0A);
    chk(pseq == p0, "R7 idle after one-shot", pseq, p0);

    // hold mode, byte, odd lane
    mem[12] = 8'h5A; mem[13] = 8'h5A; mem[14] = 8'h5A;
    wr(3'd1, 16'd13);
    wr(3'd3, 16'd7);
    wr(3'd0, 16'h000D);
    p0 = pseq;
    for (int k = 0; k < 3; k++) req(7'h0A);
    v = p0 + 2 * INC;
    chk(mem[13] == v[7:0], "R4 hold keeps address", mem[13], v[7:0]);
    chk(mem[12] == 8'h5A && mem[14] == 8'h5A, "R5 odd lane only", {mem[12], mem[14]}, 16'h5A5A);

    // wrap at top of buffer
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'd62);
    wr(3'd3, 16'd1);
    wr(3'd0, 16'h0001);
    p0 = pseq;
    req(7'h0A); req(7'h0A);
    chk(memw(62) == p0, "R4 word at top", memw(62), p0);
    chk(memw(0) == p0 + INC, "R4 wrap to zero", memw(0), p0 + INC);

    repeat (4) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
      $finish;
    end
  end
endmodule